// File: doc/BRIEF.md
# Banked Register File for a 16-bit Core

This block is the general-purpose register storage of a small 16-bit processor. It keeps two banks of working registers. Each bank holds four data registers, two address registers and a frame-base register. A bank-select input decides which bank every banked access reaches. Outside the banks sit a static-base register and two stack pointers, one for user mode and one for interrupt mode. A stack-select input decides which stack pointer answers to the stack-pointer selector.

There are two combinational read ports and one write port, and the write port takes effect on the rising clock edge. Each port carries a 4-bit register selector and a 2-bit access size. The size is a 16-bit word, the low byte, the high byte, or a 32-bit pair. Byte access exists only on the first two data registers. Pairs are fixed: the first data register pairs with the third, the second with the fourth, and the two address registers pair with each other. A request that the addressed register cannot honour writes nothing, and a read of it returns zero. The core's decoder drives the selectors. Its flag logic drives the two select inputs.

Top module: `banked_regfile`

## Requirements
- R1: Selector codes 0, 1, 2 and 3 name data registers D0..D3. With size code 0 (word), a write stores wr_data[15:0] and a later read returns it in bits 15:0.
- R2: On D0 and D1 only, size code 1 names the low byte and size code 2 the high byte. A byte write stores wr_data[7:0] into that byte and keeps the other byte. A byte read returns the byte in bits 7:0, with bits 31:8 zero.
- R3: Size code 3 (pair) on selector 0 accesses {D2,D0} and on selector 1 accesses {D3,D1}. The register named second occupies bits 15:0. A pair write updates both halves at the same edge.
- R4: Selector codes 4 and 5 name address registers X0 and X1 for word access. Size code 3 on selector 4 accesses {X1,X0}.
- R5: D0..D3, X0, X1 and the frame-base register exist once per bank. Every access to them goes to bank bank_sel, and the other bank is left untouched.
- R6: Selector code 8 with word size reaches the user stack pointer when stk_sel is 0 and the interrupt stack pointer when stk_sel is 1. Both stack pointers are shared by the two banks.
- R7: Selector code 6 names the banked frame-base register. Selector code 7 names the static-base register, which is shared by the two banks. Both allow word access only.
- R8: A read of a register that is being written in the same cycle returns the old contents. The new contents appear from the next cycle.
- R9: Selector codes 9 to 15 at any size are not supported. Neither is a byte size outside D0/D1, nor a pair size outside selectors 0, 1 and 4. Such a write changes no register, and such a read returns zero.
- R10: A synchronous reset clears every register of both banks, the static-base register and both stack pointers to zero. Reset takes priority over a write in the same cycle.
- R11: A word read returns the register in bits 15:0 with bits 31:16 zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bank_sel | input | 1 | Selects the register bank for banked accesses |
| stk_sel | input | 1 | 0 picks the user stack pointer, 1 the interrupt stack pointer |
| wr_en | input | 1 | Write request |
| wr_sel | input | 4 | Write register selector |
| wr_size | input | 2 | Write access size (0 word, 1 low byte, 2 high byte, 3 pair) |
| wr_data | input | 32 | Write data; the upper half is used by pairs only |
| ra_sel | input | 4 | Read port A register selector |
| ra_size | input | 2 | Read port A access size |
| ra_data | output | 32 | Read port A data |
| rb_sel | input | 4 | Read port B register selector |
| rb_size | input | 2 | Read port B access size |
| rb_data | output | 32 | Read port B data |

## Verification
The two functions that can land in one cycle are a write and a read of the same register. This happens for words, bytes and pairs alike. To provoke it, the bench aims read port A at the write's target before the edge and compares the value with the pre-write model. It then compares the value again after the edge against the updated model. A full sweep over banks, stack modes, selectors and sizes checks both read ports after every write. This shows that an ignored or bank-specific write left every other location alone.

// File: rtl/rf_pkg.sv
package rf_pkg;

  typedef enum logic [1:0] {
    SZ_WORD = 2'd0,
    SZ_BLO  = 2'd1,
    SZ_BHI  = 2'd2,
    SZ_PAIR = 2'd3
  } acc_size_e;

  localparam logic [3:0] SEL_D0   = 4'd0;
  localparam logic [3:0] SEL_D1   = 4'd1;
  localparam logic [3:0] SEL_X0   = 4'd4;
  localparam logic [3:0] SEL_STAT = 4'd7;
  localparam logic [3:0] SEL_STK  = 4'd8;

  // registers duplicated per bank: D0..D3, X0, X1, frame base
  localparam int NUM_BANKED = 7;

  // is this selector / size combination supported
  function automatic logic acc_legal(input logic [3:0] sel, input logic [1:0] size);
    logic ok;
    case (acc_size_e'(size))
      SZ_WORD: ok = (sel <= SEL_STK);
      SZ_BLO,
      SZ_BHI:  ok = (sel == SEL_D0) || (sel == SEL_D1);
      default: ok = (sel == SEL_D0) || (sel == SEL_D1) || (sel == SEL_X0);
    endcase
    return ok;
  endfunction

  // banked index of the upper half of a pair
  function automatic logic [2:0] pair_upper(input logic [3:0] sel);
    logic [2:0] hi;
    case (sel)
      SEL_D0:  hi = 3'd2;
      SEL_D1:  hi = 3'd3;
      default: hi = 3'd5;
    endcase
    return hi;
  endfunction

endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode
  import rf_pkg::*;
(
  input  logic       wr_en,
  input  logic [3:0] sel,
  input  logic [1:0] size,
  output logic       accept,
  output logic       to_bank,
  output logic       to_shared
);
  assign accept    = wr_en && acc_legal(sel, size);
  assign to_bank   = accept && (sel < 4'(NUM_BANKED));
  assign to_shared = accept && ((sel == SEL_STAT) || (sel == SEL_STK));
endmodule

// File: rtl/rf_bank.sv
module rf_bank
  import rf_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = NUM_BANKED
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [3:0]               sel,
  input  logic [1:0]               size,
  input  logic [2*DW-1:0]          wd,
  output logic [NREG-1:0][DW-1:0]  q
);
  localparam int HB = DW / 2;
  localparam int IW = $clog2(NREG);

  logic [IW-1:0] idx;
  logic [IW-1:0] hidx;

  assign idx  = sel[IW-1:0];
  assign hidx = IW'(pair_upper(sel));

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (we) begin
      case (acc_size_e'(size))
        SZ_WORD: q[idx]          <= wd[DW-1:0];
        SZ_BLO:  q[idx][HB-1:0]  <= wd[HB-1:0];
        SZ_BHI:  q[idx][DW-1:HB] <= wd[HB-1:0];
        default: begin
          q[idx]  <= wd[DW-1:0];
          q[hidx] <= wd[2*DW-1:DW];
        end
      endcase
    end
  end
endmodule

// File: rtl/rf_shared.sv
module rf_shared
  import rf_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [3:0]    sel,
  input  logic          stk_sel,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] sb_q,
  output logic [DW-1:0] sp_q
);
  logic [DW-1:0] usp_q;
  logic [DW-1:0] isp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sb_q  <= '0;
      usp_q <= '0;
      isp_q <= '0;
    end else if (we) begin
      if (sel == SEL_STAT) sb_q  <= wd;
      else if (stk_sel)    isp_q <= wd;
      else                 usp_q <= wd;
    end
  end

  assign sp_q = stk_sel ? isp_q : usp_q;
endmodule

// File: rtl/rf_rdmux.sv
module rf_rdmux
  import rf_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = NUM_BANKED
) (
  input  logic [NREG-1:0][DW-1:0] q,
  input  logic [DW-1:0]           sb,
  input  logic [DW-1:0]           sp,
  input  logic [3:0]              sel,
  input  logic [1:0]              size,
  input  logic                    legal,
  output logic [2*DW-1:0]         data
);
  localparam int HB = DW / 2;
  localparam int IW = $clog2(NREG);

  logic [DW-1:0] word;

  always_comb begin
    if (sel < 4'(NREG))        word = q[sel[IW-1:0]];
    else if (sel == SEL_STAT)  word = sb;
    else                       word = sp;

    data = '0;
    if (legal) begin
      case (acc_size_e'(size))
        SZ_WORD: data[DW-1:0] = word;
        SZ_BLO:  data[HB-1:0] = word[HB-1:0];
        SZ_BHI:  data[HB-1:0] = word[DW-1:HB];
        default: data = {q[IW'(pair_upper(sel))], word};
      endcase
    end
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import rf_pkg::*;
#(
  parameter int DW        = 16,
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic              stk_sel,
  input  logic              wr_en,
  input  logic [3:0]        wr_sel,
  input  logic [1:0]        wr_size,
  input  logic [2*DW-1:0]   wr_data,
  input  logic [3:0]        ra_sel,
  input  logic [1:0]        ra_size,
  output logic [2*DW-1:0]   ra_data,
  input  logic [3:0]        rb_sel,
  input  logic [1:0]        rb_size,
  output logic [2*DW-1:0]   rb_data
);
  // named internal events
  logic wr_ok;
  logic wr_bank_hit;
  logic wr_shared_hit;
  logic ra_ok;
  logic rb_ok;

  logic [NUM_BANKED-1:0][DW-1:0] bank_q [NUM_BANKS];
  logic [NUM_BANKED-1:0][DW-1:0] cur_q;
  logic [DW-1:0]                 sb_q;
  logic [DW-1:0]                 sp_q;

  rf_wr_decode u_wdec (
    .wr_en     (wr_en),
    .sel       (wr_sel),
    .size      (wr_size),
    .accept    (wr_ok),
    .to_bank   (wr_bank_hit),
    .to_shared (wr_shared_hit)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    rf_bank #(.DW(DW), .NREG(NUM_BANKED)) u_bank (
      .clk  (clk),
      .rst  (rst),
      .we   (wr_bank_hit && (bank_sel == BANK_W'(b))),
      .sel  (wr_sel),
      .size (wr_size),
      .wd   (wr_data),
      .q    (bank_q[b])
    );
  end

  rf_shared #(.DW(DW)) u_shared (
    .clk     (clk),
    .rst     (rst),
    .we      (wr_shared_hit),
    .sel     (wr_sel),
    .stk_sel (stk_sel),
    .wd      (wr_data[DW-1:0]),
    .sb_q    (sb_q),
    .sp_q    (sp_q)
  );

  assign cur_q = bank_q[bank_sel];
  assign ra_ok = acc_legal(ra_sel, ra_size);
  assign rb_ok = acc_legal(rb_sel, rb_size);

  rf_rdmux #(.DW(DW), .NREG(NUM_BANKED)) u_rda (
    .q(cur_q), .sb(sb_q), .sp(sp_q),
    .sel(ra_sel), .size(ra_size), .legal(ra_ok), .data(ra_data)
  );

  rf_rdmux #(.DW(DW), .NREG(NUM_BANKED)) u_rdb (
    .q(cur_q), .sb(sb_q), .sp(sp_q),
    .sel(rb_sel), .size(rb_size), .legal(rb_ok), .data(rb_data)
  );
endmodule

// File: rtl/rf_chk.sv
module rf_chk #(
  parameter int DW     = 16,
  parameter int BANK_W = 1
) (
  input logic              clk,
  input logic              rst,
  input logic [BANK_W-1:0] bank_sel,
  input logic              stk_sel,
  input logic [3:0]        wr_sel,
  input logic [1:0]        wr_size,
  input logic [2*DW-1:0]   wr_data,
  input logic [3:0]        ra_sel,
  input logic [1:0]        ra_size,
  input logic [2*DW-1:0]   ra_data,
  input logic [2*DW-1:0]   rb_data,
  input logic              wr_ok,
  input logic              ra_ok,
  input logic              rb_ok
);
  localparam int HB = DW / 2;

  // R9
  illegal_read_a_chk: assert property (@(posedge clk) disable iff (rst)
    !ra_ok |-> ra_data == '0);

  // R9
  illegal_read_b_chk: assert property (@(posedge clk) disable iff (rst)
    !rb_ok |-> rb_data == '0);

  // R2
  byte_read_narrow_chk: assert property (@(posedge clk) disable iff (rst)
    (ra_ok && (ra_size == 2'd1 || ra_size == 2'd2)) |-> ra_data[2*DW-1:HB] == '0);

  // R11
  word_read_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (ra_ok && ra_size == 2'd0) |-> ra_data[2*DW-1:DW] == '0);

  // R1
  word_write_visible_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && wr_size == 2'd0) |=>
      (ra_sel != $past(wr_sel) || ra_size != 2'd0 ||
       bank_sel != $past(bank_sel) || stk_sel != $past(stk_sel) ||
       ra_data == {{DW{1'b0}}, $past(wr_data[DW-1:0])}));

  // R9
  idle_read_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_ok |=>
      (!($stable(ra_sel) && $stable(ra_size) && $stable(bank_sel) && $stable(stk_sel)) ||
       $stable(ra_data)));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (ra_data == '0 && rb_data == '0));
endmodule

bind banked_regfile rf_chk #(.DW(DW), .BANK_W(BANK_W)) u_rf_chk (
  .clk(clk), .rst(rst), .bank_sel(bank_sel), .stk_sel(stk_sel),
  .wr_sel(wr_sel), .wr_size(wr_size), .wr_data(wr_data),
  .ra_sel(ra_sel), .ra_size(ra_size), .ra_data(ra_data), .rb_data(rb_data),
  .wr_ok(wr_ok), .ra_ok(ra_ok), .rb_ok(rb_ok)
);

// File: tb/banked_regfile_test.sv
module banked_regfile_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        bank_sel, stk_sel, wr_en;
  logic [3:0]  wr_sel, ra_sel, rb_sel;
  logic [1:0]  wr_size, ra_size, rb_size;
  logic [31:0] wr_data, ra_data, rb_data;

  int n_chk  = 0;
  int n_fail = 0;

  // reference state
  logic [15:0] mb [2][7];
  logic [15:0] m_sb, m_usp, m_isp;

  banked_regfile uut (
    .clk(clk), .rst(rst), .bank_sel(bank_sel), .stk_sel(stk_sel),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_size(wr_size), .wr_data(wr_data),
    .ra_sel(ra_sel), .ra_size(ra_size), .ra_data(ra_data),
    .rb_sel(rb_sel), .rb_size(rb_size), .rb_data(rb_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit ok_combo(int s, int z);
    if (z == 0) return s <= 8;
    if (z == 3) return s == 0 || s == 1 || s == 4;
    return s == 0 || s == 1;
  endfunction

  function automatic logic [15:0] word_of(int b, int k, int s);
    if (s < 7)  return mb[b][s];
    if (s == 7) return m_sb;
    return (k != 0) ? m_isp : m_usp;
  endfunction

  function automatic logic [31:0] expect_rd(int b, int k, int s, int z);
    logic [15:0] w;
    if (!ok_combo(s, z)) return 32'h0;
    w = word_of(b, k, s);
    case (z)
      0: return {16'h0, w};
      1: return {24'h0, w[7:0]};
      2: return {24'h0, w[15:8]};
      default: return {mb[b][(s == 0) ? 2 : (s == 1) ? 3 : 5], w};
    endcase
  endfunction

  function automatic string tag_of(int s, int z);
    if (!ok_combo(s, z)) return "R9";
    if (z == 3) return (s == 4) ? "R4" : "R3";
    if (z != 0) return "R2";
    if (s < 4)  return "R1";
    if (s < 6)  return "R4";
    if (s < 8)  return "R7";
    return "R6";
  endfunction

  task automatic model_write(int b, int k, int s, int z, logic [31:0] d);
    if (!ok_combo(s, z)) return;
    case (z)
      0: begin
        if (s < 7)       mb[b][s] = d[15:0];
        else if (s == 7) m_sb = d[15:0];
        else if (k != 0) m_isp = d[15:0];
        else             m_usp = d[15:0];
      end
      1: mb[b][s][7:0]  = d[7:0];
      2: mb[b][s][15:8] = d[7:0];
      default: begin
        mb[b][s] = d[15:0];
        mb[b][(s == 0) ? 2 : (s == 1) ? 3 : 5] = d[31:16];
      end
    endcase
  endtask

  task automatic model_clear();
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < 7; r++) mb[b][r] = 16'h0;
    m_sb = 16'h0; m_usp = 16'h0; m_isp = 16'h0;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // read everything through both ports in every bank and stack mode
  task automatic sweep(string force_tag);
    for (int b = 0; b < 2; b++)
      for (int k = 0; k < 2; k++)
        for (int s = 0; s < 16; s++)
          for (int z = 0; z < 4; z++) begin
            bank_sel = b[0]; stk_sel = k[0];
            ra_sel = 4'(s);      ra_size = 2'(z);
            rb_sel = 4'(15 - s); rb_size = 2'(3 - z);
            #1;
            check((force_tag != "") ? force_tag : tag_of(s, z), ra_data, expect_rd(b, k, s, z));
            check((force_tag != "") ? force_tag : tag_of(15 - s, 3 - z), rb_data,
                  expect_rd(b, k, 15 - s, 3 - z));
          end
  endtask

  // write with port A aimed at the target: old value before the edge (R8)
  task automatic do_write(int b, int k, int s, int z, logic [31:0] d);
    @(negedge clk);
    bank_sel = b[0]; stk_sel = k[0];
    wr_en = 1'b1; wr_sel = 4'(s); wr_size = 2'(z); wr_data = d;
    ra_sel = 4'(s); ra_size = 2'(z);
    #1;
    check("R8", ra_data, expect_rd(b, k, s, z));
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    model_write(b, k, s, z, d);
    check("R8", ra_data, expect_rd(b, k, s, z));
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] pat;
    rst = 1'b1; wr_en = 1'b0; bank_sel = 1'b0; stk_sel = 1'b0;
    wr_sel = '0; wr_size = '0; wr_data = '0;
    ra_sel = '0; ra_size = '0; rb_sel = '0; rb_size = '0;
    model_clear();
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    sweep("R10");

    // every bank, stack mode, selector and size, then full read-back
    pat = 32'h1357_9BDF;
    for (int b = 0; b < 2; b++)
      for (int k = 0; k < 2; k++)
        for (int s = 0; s < 16; s++)
          for (int z = 0; z < 4; z++) begin
            pat = pat * 32'h0019_660D + 32'h3C6E_F35F;
            do_write(b, k, s, z, pat);
            sweep("");
          end

    // R5: same register, distinct banks
    do_write(0, 0, 0, 0, 32'h0000_A1A1);
    do_write(1, 0, 0, 0, 32'h0000_B2B2);
    bank_sel = 1'b0; ra_sel = 4'd0; ra_size = 2'd0; #1;
    check("R5", ra_data, 32'h0000_A1A1);
    bank_sel = 1'b1; #1;
    check("R5", ra_data, 32'h0000_B2B2);

    // R6: two stack pointers, shared across banks
    do_write(0, 0, 8, 0, 32'h0000_1111);
    do_write(1, 1, 8, 0, 32'h0000_2222);
    bank_sel = 1'b1; stk_sel = 1'b0; ra_sel = 4'd8; ra_size = 2'd0; #1;
    check("R6", ra_data, 32'h0000_1111);
    bank_sel = 1'b0; stk_sel = 1'b1; #1;
    check("R6", ra_data, 32'h0000_2222);

    // R11: pair data on a word write keeps only the low half
    do_write(0, 0, 3, 0, 32'hFFFF_5A5A);
    bank_sel = 1'b0; ra_sel = 4'd3; ra_size = 2'd0; #1;
    check("R11", ra_data, 32'h0000_5A5A);

    // R10: reset wins over a simultaneous write
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b1; wr_sel = 4'd0; wr_size = 2'd0; wr_data = 32'hDEAD_BEEF;
    @(posedge clk);
    #1 rst = 1'b0; wr_en = 1'b0;
    model_clear();
    sweep("R10");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule